// File: doc/BRIEF.md
# Data-Processing ALU With Condition Flags

This block carries out the sixteen register-to-register data-processing operations of a 32-bit integer datapath. It receives a first operand, a second operand that has already passed through the barrel shifter, a 4-bit operation code, a flag-update request, the current negative/zero/carry/overflow flags and the shifter's carry-out. It returns the operation result, a destination write-enable and the flag set that the datapath should hold after the operation.

The operations fall into three groups. The first group is arithmetic: add and subtract, both operand orders of subtract, and forms that fold in the carry flag. The second group is bitwise logic and moves. The third group is test/compare, which only computes flags. All outputs are registered, so a result appears one clock after its operands. Operand shifting, condition evaluation and the register file sit outside this block.

Top module: `dp_alu_core`

## Requirements
- R1: Operation codes 0100, 0010 and 0011 return a+b, a-b and b-a. Code 0101 returns a+b+C, where C is flags_i[1] and a/b are opa_i/opb_i.
- R2: Code 0110 returns a-b+C-1 and code 0111 returns b-a+C-1, both modulo 2^32.
- R3: Codes 0000, 0001, 1100 and 1110 return a AND b, a XOR b, a OR b and a AND NOT b.
- R4: Code 1101 returns b and code 1111 returns NOT b. In both cases opa_i has no effect on any output.
- R5: Codes 1000, 1001, 1010 and 1011 compute AND, XOR, a-b and a+b on result_o, and wr_en_o is 0. Every other code gives wr_en_o = 1.
- R6: When set_flags_i is 0, flags_o equals flags_i. The flag order is {N,Z,C,V} in bits [3:0].
- R7: When set_flags_i is 1, N equals result bit 31, and Z is 1 exactly when the result is zero.
- R8: For arithmetic codes (0010 to 0111, 1010, 1011) with set_flags_i = 1, C is the unsigned carry-out of the addition. For subtracting forms, C is 1 when no borrow occurs.
- R9: For arithmetic codes with set_flags_i = 1, V is 1 exactly when the signed result falls outside the 32-bit two's-complement range.
- R10: For logical, move and bitwise test codes with set_flags_i = 1, C takes shift_c_i and V keeps flags_i[0].
- R11: Outputs update one clock after the inputs are sampled. While rst_n is low, result_o, wr_en_o and flags_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request to update flags |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Shifted second operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_c_i | input | 1 | Barrel shifter carry-out |
| result_o | output | 32 | Operation result (registered) |
| wr_en_o | output | 1 | Destination write enable (registered) |
| flags_o | output | 4 | Next flags {N,Z,C,V} (registered) |

## Verification
The hardest cases to reach are the carry-folding subtracts, SBC and RSC, at the borrow boundary. With C = 0, equal operands must give all-ones with C clear. With C = 1, they must give zero with C set. Signed overflow must also be reached on both operand orders. Uniform random operands almost never hit equal values or the sign-boundary pairs. The stimulus therefore adds directed vectors built around 0, 0x7FFFFFFF, 0x80000000 and equal operand pairs, sweeps every code against each carry-in value, and mixes in random vectors whose operands are drawn from a small pool of such edge values.

// File: rtl/dp_alu_pkg.sv
// Package: shared operation codes, flag layout and decode record for the
// data-processing ALU. Assumes a 4-bit operation code.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
        OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
        OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
        OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
    } alu_op_e;

    // Carry-in source for the adder
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    // Bit positions inside the 4-bit flag vector
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef struct packed {
        logic     is_arith;  // result comes from the adder
        logic     swap;      // reverse operand order
        logic     inv_sub;   // subtrahend is inverted
        cin_sel_e cin_sel;   // carry-in source
        logic     no_write;  // flags-only operation
    } alu_ctl_t;

endpackage

// File: rtl/dp_alu_decode.sv
// Operation decoder: turns the 4-bit code into adder steering and write
// control. Purely combinational; assumes codes follow dp_alu_pkg::alu_op_e.
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op_i,
    output alu_ctl_t   ctl_o
);

    // Map each operation code to its control record
    always_comb begin
        ctl_o          = '0;
        ctl_o.cin_sel  = CIN_ZERO;
        ctl_o.no_write = (op_i[3:2] == 2'b10);
        unique case (alu_op_e'(op_i))
            OP_ADD, OP_CMN: begin
                ctl_o.is_arith = 1'b1;
            end
            OP_ADC: begin
                ctl_o.is_arith = 1'b1;
                ctl_o.cin_sel  = CIN_FLAG;
            end
            OP_SUB, OP_CMP: begin
                ctl_o.is_arith = 1'b1;
                ctl_o.inv_sub  = 1'b1;
                ctl_o.cin_sel  = CIN_ONE;
            end
            OP_RSB: begin
                ctl_o.is_arith = 1'b1;
                ctl_o.swap     = 1'b1;
                ctl_o.inv_sub  = 1'b1;
                ctl_o.cin_sel  = CIN_ONE;
            end
            OP_SBC: begin
                ctl_o.is_arith = 1'b1;
                ctl_o.inv_sub  = 1'b1;
                ctl_o.cin_sel  = CIN_FLAG;
            end
            OP_RSC: begin
                ctl_o.is_arith = 1'b1;
                ctl_o.swap     = 1'b1;
                ctl_o.inv_sub  = 1'b1;
                ctl_o.cin_sel  = CIN_FLAG;
            end
            default: begin
                ctl_o.is_arith = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dp_alu_adder.sv
// Adder with carry-in: returns sum, unsigned carry-out and signed overflow.
// Assumes callers have already inverted the subtrahend for subtraction.
module dp_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W:0] wide;

    // Full-width addition with one extra bit for the carry
    always_comb begin
        wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
    end

    // Overflow: equal input signs, result sign differs
    always_comb begin
        ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
    end

endmodule

// File: rtl/dp_alu_logic.sv
// Bitwise unit: logical, move and bitwise-test operations.
// Assumes arithmetic codes are handled elsewhere; returns zero for them.
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);

    // Select the bitwise function for the code
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_core.sv
// Data-processing ALU top: decodes the code, steers the adder or bitwise
// unit, forms the next flags and registers all outputs (one-cycle latency).
// Assumes opb_i is already shifted and shift_c_i is the matching carry.
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic         set_flags_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [3:0]   flags_i,
    input  logic         shift_c_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic [3:0]   flags_o
);

    localparam int MSB = W - 1;

    alu_ctl_t       ctl;
    logic [W-1:0]   add_x, add_y, add_sum, logic_res, res_d;
    logic           add_cin, add_cout, add_ovf;
    logic [3:0]     flags_d;
    logic           live_q;

    dp_alu_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    // Order operands and invert the subtrahend for subtracting forms
    always_comb begin
        add_x = ctl.swap ? opb_i : opa_i;
        add_y = ctl.swap ? opa_i : opb_i;
        if (ctl.inv_sub) add_y = ~add_y;
        unique case (ctl.cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = flags_i[FLAG_C];
            default:  add_cin = 1'b0;
        endcase
    end

    dp_alu_adder #(.W(W)) u_add (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    dp_alu_logic #(.W(W)) u_log (
        .op_i  (op_i),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (logic_res)
    );

    // Pick the result source
    always_comb res_d = ctl.is_arith ? add_sum : logic_res;

    // Form next flags, holding them all when no update is requested
    always_comb begin
        flags_d = flags_i;
        if (set_flags_i) begin
            flags_d[FLAG_N] = res_d[MSB];
            flags_d[FLAG_Z] = (res_d == '0);
            flags_d[FLAG_C] = ctl.is_arith ? add_cout : shift_c_i;
            flags_d[FLAG_V] = ctl.is_arith ? add_ovf  : flags_i[FLAG_V];
        end
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= '0;
            live_q   <= 1'b0;
        end else begin
            result_o <= res_d;
            wr_en_o  <= !ctl.no_write;
            flags_o  <= flags_d;
            live_q   <= 1'b1;
        end
    end

    // R5: flags-only codes never write a destination
    p_test_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(op_i[3:2] == 2'b10) |-> !wr_en_o);

    // R6: flags pass through unchanged without an update request
    p_hold_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!set_flags_i) |-> flags_o == $past(flags_i));

    // R7: N and Z agree with the registered result
    p_nz_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(set_flags_i) |->
            (flags_o[FLAG_N] == result_o[MSB]) && (flags_o[FLAG_Z] == (result_o == '0)));

    // R10: bitwise codes take C from the shifter and keep V
    p_logic_cv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(set_flags_i) && $past(!ctl.is_arith) |->
            (flags_o[FLAG_C] == $past(shift_c_i)) && (flags_o[FLAG_V] == $past(flags_i[FLAG_V])));

    // R9: overflow with opposite-sign add inputs is impossible
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(set_flags_i) && $past(op_i == 4'b0100)
            && $past(opa_i[MSB] != opb_i[MSB]) |-> !flags_o[FLAG_V]);

endmodule

// File: tb/dp_alu_core_tb.sv
module dp_alu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        set_flags_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [3:0]  flags_i = '0;
    logic        shift_c_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dp_alu_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
        .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i), .shift_c_i(shift_c_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    // Reference model written from the requirements
    function automatic void model(input logic [3:0] op, input logic s,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] f, input logic sc,
                                  output logic [31:0] r, output logic we,
                                  output logic [3:0] nf);
        longint ua = longint'(a), ub = longint'(b);
        longint sa = longint'(signed'(a)), sb = longint'(signed'(b));
        longint c  = longint'(f[1]);
        longint ur, sr;
        logic arith = 1'b1;
        case (op)
            4'b0100, 4'b1011: begin ur = ua + ub;         sr = sa + sb;         end
            4'b0101:          begin ur = ua + ub + c;     sr = sa + sb + c;     end
            4'b0010, 4'b1010: begin ur = ua - ub;         sr = sa - sb;         end
            4'b0011:          begin ur = ub - ua;         sr = sb - sa;         end
            4'b0110:          begin ur = ua - ub + c - 1; sr = sa - sb + c - 1; end
            4'b0111:          begin ur = ub - ua + c - 1; sr = sb - sa + c - 1; end
            default: begin arith = 1'b0; ur = 0; sr = 0; end
        endcase
        case (op)
            4'b0000, 4'b1000: r = a & b;
            4'b0001, 4'b1001: r = a ^ b;
            4'b1100:          r = a | b;
            4'b1101:          r = b;
            4'b1110:          r = a & ~b;
            4'b1111:          r = ~b;
            default:          r = ur[31:0];
        endcase
        we = (op[3:2] != 2'b10);
        nf = f;
        if (s) begin
            nf[3] = r[31];
            nf[2] = (r == 32'd0);
            if (arith) begin
                if (op inside {4'b0100, 4'b0101, 4'b1011}) nf[1] = (ur > 64'shFFFF_FFFF);
                else                                         nf[1] = (ur >= 0);
                nf[0] = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000);
            end else begin
                nf[1] = sc;
            end
        end
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic s);
        if (!s) return "R6";
        if (op[3:2] == 2'b10) return "R5";
        if (op == 4'b0110 || op == 4'b0111) return "R2";
        if (op == 4'b1101 || op == 4'b1111) return "R4";
        if (op inside {4'b0000, 4'b0001, 4'b1100, 4'b1110}) return "R10";
        return "R8/R9";
    endfunction

    // Apply one vector at a falling edge; check one cycle later at the next falling edge
    task automatic apply(input logic [3:0] op, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f, input logic sc,
                         input string tag);
        logic [31:0] er; logic ew; logic [3:0] ef;
        op_i = op; set_flags_i = s; opa_i = a; opb_i = b; flags_i = f; shift_c_i = sc;
        model(op, s, a, b, f, sc, er, ew, ef);
        @(negedge clk);
        n_vec++;
        if (result_o !== er || wr_en_o !== ew || flags_o !== ef) begin
            n_bad++;
            $display("FAIL %s op=%b s=%0b a=%h b=%h f=%b: got res=%h we=%0b fl=%b, exp res=%h we=%0b fl=%b",
                     tag, op, s, a, b, f, result_o, wr_en_o, flags_o, er, ew, ef);
        end
    endtask

    function automatic logic [31:0] edge_val(input int k);
        case (k % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h8000_0001;
            6: return 32'h5555_5555;
            default: return $urandom;
        endcase
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, exp fewer", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        opa_i = 32'hDEAD_BEEF; opb_i = 32'h1234_5678; op_i = 4'b0100;
        set_flags_i = 1'b1; flags_i = 4'b1111;
        repeat (3) @(negedge clk);
        n_vec++;
        if (result_o !== '0 || wr_en_o !== 1'b0 || flags_o !== 4'b0) begin
            n_bad++;
            $display("FAIL R11 reset: got res=%h we=%0b fl=%b, exp 0/0/0", result_o, wr_en_o, flags_o);
        end
        rst_n = 1'b1;

        // R1 R7 R8 R9: add overflow, carry-out, subtract to zero
        apply(4'b0100, 1, 32'h7FFF_FFFF, 32'h1, 4'b0000, 0, "R1/R9");
        apply(4'b0100, 1, 32'hFFFF_FFFF, 32'h1, 4'b0000, 0, "R7/R8");
        apply(4'b0010, 1, 32'h5, 32'h5, 4'b0000, 0, "R1/R8");
        apply(4'b0010, 1, 32'h3, 32'h5, 4'b0000, 0, "R8 borrow");
        apply(4'b0011, 1, 32'h80000000, 32'h1, 4'b0000, 0, "R1/R9 rsb");
        apply(4'b0101, 1, 32'h10, 32'h20, 4'b0010, 0, "R1 adc");
        // R2: carry-folding subtracts at the borrow boundary
        apply(4'b0110, 1, 32'h7, 32'h7, 4'b0000, 0, "R2 sbc c0");
        apply(4'b0110, 1, 32'h7, 32'h7, 4'b0010, 0, "R2 sbc c1");
        apply(4'b0111, 1, 32'h9, 32'h9, 4'b0000, 0, "R2 rsc c0");
        apply(4'b0111, 1, 32'h9, 32'h9, 4'b0010, 0, "R2 rsc c1");
        apply(4'b0111, 1, 32'h1, 32'h80000000, 4'b0010, 0, "R2/R9 rsc ovf");
        // R3 R10: bitwise with shifter carry, V held
        apply(4'b1110, 1, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0001, 1, "R3/R10 bic");
        apply(4'b0001, 1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0011, 0, "R3/R10 eor");
        // R4: moves ignore first operand
        apply(4'b1101, 1, 32'h1111_1111, 32'h8000_0000, 4'b0000, 1, "R4 mov");
        apply(4'b1101, 1, 32'hFFFF_FFFF, 32'h8000_0000, 4'b0000, 1, "R4 mov opa");
        apply(4'b1111, 1, 32'h0, 32'hFFFF_FFFF, 4'b1001, 0, "R4 mvn");
        // R5: flags-only codes
        apply(4'b1010, 1, 32'h4, 32'h4, 4'b0000, 0, "R5 cmp");
        apply(4'b1000, 1, 32'h0F, 32'hF0, 4'b0001, 1, "R5 tst");
        // R6: hold
        apply(4'b0100, 0, 32'h7FFF_FFFF, 32'h1, 4'b1010, 1, "R6 hold");

        // Every code against both carry-in values and both S settings
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 4; k++)
                apply(op[3:0], k[0], edge_val(op + k), edge_val(op + 2 * k + 3),
                      {2'b01, k[1], 1'b1}, k[1], tag_of(op[3:0], k[0]));

        // Random mix with edge-value pools
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  rop = 4'($urandom);
            logic        rs  = ($urandom % 4) != 0;
            logic [31:0] ra  = (i % 3 == 0) ? edge_val($urandom) : $urandom;
            logic [31:0] rb  = (i % 3 == 1) ? ra : ((i % 2 == 0) ? edge_val($urandom) : $urandom);
            apply(rop, rs, ra, rb, 4'($urandom), 1'($urandom), tag_of(rop, rs));
        end

        finish_run();
    end

endmodule